// File: doc/BRIEF.md
# Transmit Phase-Alignment Sequencer

This block steps a serial transmitter through the start-up routine that lines up its internal parallel clock with the user transmit clock when the elastic transmit buffer is not in the path. It holds everything low until the clock-stable input reports that all clocks have settled. It then raises a persistent alignment-enable output. After a fixed settling interval it pulses a set-phase output. The length of that pulse depends on the PLL divider code. When the pulse ends, the sequencer raises a done flag.

Alignment-enable must stay high once raised, because dropping it loses the alignment. Only a restart event drops it. Three events cause a restart: a tile reset, the PLL leaving power-down, and a change of clock source. Any of them sends the sequencer back to its first state, where it waits for stable clocks again. One instance drives the shared alignment outputs for both transceivers of a tile.

All pins are plain control and status levels. No data stream passes through this block, so it has no valid/ready handshake.

Top module: `txpa_seq`

## Requirements
- R1: After reset or a restart, `align_en` stays low while `clocks_stable` is low. In the cycle after `clocks_stable` is sampled high, `align_en` becomes high.
- R2: Once high, `align_en` stays high until a restart event, whatever `clocks_stable` and `div_sel` do.
- R3: `set_phase` rises after `align_en` has been high, with `set_phase` low, for exactly `PRE_WAIT` cycles (default 32).
- R4: `set_phase` stays high for `BASE_HOLD` cycles when `div_sel` is 1, for 2×`BASE_HOLD` cycles when it is 2, and for 4×`BASE_HOLD` cycles when it is 3. With the defaults these are 4096, 8192 and 16384 cycles. `div_sel` is sampled in the last settling cycle.
- R5: The unsupported code `div_sel` = 0 selects the longest hold, 4×`BASE_HOLD` cycles.
- R6: `align_done` rises in the cycle in which `set_phase` falls. It is never high together with `set_phase`, and it stays high, with `align_en` still high, until a restart event.
- R7: When `tile_reset` is sampled high, `align_en`, `set_phase` and `align_done` are all low in the next cycle, and the sequence starts over.
- R8: A rising edge of `pll_pwr_on` (power-down released) restarts the sequence in the same way as R7. A falling edge has no effect on the outputs.
- R9: When `clk_src_change` is sampled high, the sequence restarts in the same way as R7.
- R10: After any restart, all three outputs are low for at least one cycle before `align_en` can rise again, and it rises only through the R1 rule.
- R11: While `rst_n` is low, and in the first cycle after it is released, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User transmit clock |
| rst_n | input | 1 | Active-low asynchronous reset of the sequencer |
| clocks_stable | input | 1 | High when all clocks have settled |
| tile_reset | input | 1 | Tile reset; restarts the sequence while high |
| pll_pwr_on | input | 1 | PLL power state, high = powered; a rising edge restarts the sequence |
| clk_src_change | input | 1 | Clock source changed; restarts the sequence while high |
| div_sel | input | DIV_W | PLL divider code; selects the set-phase hold length |
| align_en | output | 1 | Persistent phase-alignment enable, shared by the tile |
| set_phase | output | 1 | Set-phase pulse, shared by the tile |
| align_done | output | 1 | High once the alignment routine has completed |

## Verification
The bench keeps `PRE_WAIT` at its default of 32, so the settling interval is checked at its real length. It sets `BASE_HOLD` to 16, which gives holds of 16, 32, 64 and 64 cycles for codes 1, 2, 3 and 0. With these short holds, every divider code and every restart source can be driven through dozens of complete runs. It also brings aborts within reach at each phase of the sequence: during settling, during the set-phase pulse, and after completion.

// File: rtl/txpa_pkg.sv
package txpa_pkg;
  typedef enum logic [1:0] {
    ST_WAIT   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_PHASE  = 2'd2,
    ST_DONE   = 2'd3
  } txpa_state_e;
endpackage

// File: rtl/txpa_event_det.sv
module txpa_event_det (
  input  logic clk,
  input  logic rst_n,
  input  logic tile_reset,
  input  logic pll_pwr_on,
  input  logic clk_src_change,
  output logic restart
);
  logic pll_q;

  // The flop resets to "powered", so a PLL that is already on after reset
  // produces no restart. A PLL held off through reset still gives an edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pll_q <= 1'b1;
    else        pll_q <= pll_pwr_on;
  end

  assign restart = tile_reset | clk_src_change | (pll_pwr_on & ~pll_q);
endmodule

// File: rtl/txpa_hold_sel.sv
module txpa_hold_sel #(
  parameter int DIV_W     = 2,
  parameter int BASE_HOLD = 4096,
  parameter int CNT_W     = 15
) (
  input  logic [DIV_W-1:0] div_sel,
  output logic [CNT_W-1:0] hold_cycles
);
  localparam logic [CNT_W-1:0] HOLD_X1 = CNT_W'(BASE_HOLD);
  localparam logic [CNT_W-1:0] HOLD_X2 = CNT_W'(2 * BASE_HOLD);
  localparam logic [CNT_W-1:0] HOLD_X4 = CNT_W'(4 * BASE_HOLD);

  always_comb begin
    case (int'(div_sel))
      1:       hold_cycles = HOLD_X1;
      2:       hold_cycles = HOLD_X2;
      default: hold_cycles = HOLD_X4; // 3 and any unsupported code
    endcase
  end
endmodule

// File: rtl/txpa_ctr.sv
module txpa_ctr #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else          cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/txpa_seq.sv
module txpa_seq #(
  parameter int PRE_WAIT  = 32,
  parameter int BASE_HOLD = 4096,
  parameter int DIV_W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clocks_stable,
  input  logic             tile_reset,
  input  logic             pll_pwr_on,
  input  logic             clk_src_change,
  input  logic [DIV_W-1:0] div_sel,
  output logic             align_en,
  output logic             set_phase,
  output logic             align_done
);
  import txpa_pkg::*;

  localparam int MAX_HOLD = 4 * BASE_HOLD;
  localparam int MAX_CNT  = (MAX_HOLD > PRE_WAIT) ? MAX_HOLD : PRE_WAIT;
  localparam int CNT_W    = $clog2(MAX_CNT + 1);
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(PRE_WAIT - 1);

  txpa_state_e      state_q, state_d;
  logic             restart;
  logic             cnt_clr;
  logic             load_hold;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] hold_cycles;
  logic [CNT_W-1:0] hold_q;

  txpa_event_det u_evt (
    .clk            (clk),
    .rst_n          (rst_n),
    .tile_reset     (tile_reset),
    .pll_pwr_on     (pll_pwr_on),
    .clk_src_change (clk_src_change),
    .restart        (restart)
  );

  txpa_hold_sel #(
    .DIV_W     (DIV_W),
    .BASE_HOLD (BASE_HOLD),
    .CNT_W     (CNT_W)
  ) u_hold (
    .div_sel     (div_sel),
    .hold_cycles (hold_cycles)
  );

  txpa_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .cnt   (cnt)
  );

  always_comb begin
    state_d   = state_q;
    cnt_clr   = 1'b0;
    load_hold = 1'b0;
    if (restart) begin
      state_d = ST_WAIT;
      cnt_clr = 1'b1;
    end else begin
      case (state_q)
        ST_WAIT: begin
          cnt_clr = 1'b1;
          if (clocks_stable) state_d = ST_SETTLE;
        end
        ST_SETTLE: begin
          if (cnt == SETTLE_LAST) begin
            state_d   = ST_PHASE;
            cnt_clr   = 1'b1;
            load_hold = 1'b1;
          end
        end
        ST_PHASE: begin
          if (cnt == hold_q - 1'b1) begin
            state_d = ST_DONE;
            cnt_clr = 1'b1;
          end
        end
        default: cnt_clr = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAIT;
      hold_q  <= '0;
    end else begin
      state_q <= state_d;
      if (load_hold) hold_q <= hold_cycles;
    end
  end

  assign align_en   = (state_q != ST_WAIT);
  assign set_phase  = (state_q == ST_PHASE);
  assign align_done = (state_q == ST_DONE);

  AST_EN_AFTER_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(align_en) |-> $past(clocks_stable)); // R1
  AST_EN_PERSISTS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(align_en) && !$past(restart)) |-> align_en); // R2
  AST_PHASE_UNDER_EN: assert property (@(posedge clk) disable iff (!rst_n)
    set_phase |-> align_en); // R3
  AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    align_done |-> (align_en && !set_phase)); // R6
  AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(align_done) |-> $fell(set_phase)); // R6
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!align_en && !set_phase && !align_done)); // R10
  AST_OUT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({set_phase, align_done})); // R6
endmodule

// File: tb/sim_txpa_seq.sv
module sim_txpa_seq;
  localparam int PRE_WAIT  = 32;
  localparam int BASE_HOLD = 16;
  localparam int DIV_W     = 2;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             clocks_stable;
  logic             tile_reset;
  logic             pll_pwr_on;
  logic             clk_src_change;
  logic [DIV_W-1:0] div_sel;
  logic             align_en, set_phase, align_done;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk; // 125 MHz

  txpa_seq #(.PRE_WAIT(PRE_WAIT), .BASE_HOLD(BASE_HOLD), .DIV_W(DIV_W)) u0 (
    .clk(clk), .rst_n(rst_n), .clocks_stable(clocks_stable),
    .tile_reset(tile_reset), .pll_pwr_on(pll_pwr_on),
    .clk_src_change(clk_src_change), .div_sel(div_sel),
    .align_en(align_en), .set_phase(set_phase), .align_done(align_done)
  );

  function automatic int exp_hold(int d);
    case (d)
      1:       return BASE_HOLD;
      2:       return 2 * BASE_HOLD;
      default: return 4 * BASE_HOLD;
    endcase
  endfunction

  function automatic int outs();
    return {29'd0, align_en, set_phase, align_done};
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive stable high and run one complete alignment, checking each phase.
  task automatic run_align(int d);
    int cnt;
    int h;
    div_sel = DIV_W'(d);
    clocks_stable = 1'b1;
    @(negedge clk);
    chk("R1 align_en after stable", int'(align_en), 1);
    cnt = 0;
    while (align_en && !set_phase && !align_done && cnt < 1000) begin
      cnt++;
      @(negedge clk);
    end
    chk("R3 settle cycles", cnt, PRE_WAIT);
    h = 0;
    while (set_phase && h < 1000) begin
      h++;
      @(negedge clk);
    end
    chk((d == 0) ? "R5 hold for code 0" : "R4 hold cycles", h, exp_hold(d));
    chk("R6 done with enable after pulse", outs(), 3'b101);
  endtask

  // Fire one restart source; ev 0 = tile reset, 1 = source change, 2 = PLL power-up.
  task automatic fire(int ev, bit stable_after, bit was_done);
    if (ev == 2) begin
      pll_pwr_on = 1'b0;
      @(negedge clk);
      if (was_done) chk("R8 falling PLL no effect", outs(), 3'b101);
      pll_pwr_on = 1'b1;
    end else if (ev == 0) tile_reset = 1'b1;
    else clk_src_change = 1'b1;
    clocks_stable = stable_after;
    @(negedge clk);
    tile_reset = 1'b0;
    clk_src_change = 1'b0;
    case (ev)
      0:       chk("R7 tile reset clears", outs(), 0);
      1:       chk("R9 source change clears", outs(), 0);
      default: chk("R8 PLL power-up clears", outs(), 0);
    endcase
  endtask

  initial begin
    int h;
    bit prev_done;
    void'($urandom(32'd20240));
    rst_n = 1'b0;
    clocks_stable = 1'b0;
    tile_reset = 1'b0;
    pll_pwr_on = 1'b1;
    clk_src_change = 1'b0;
    div_sel = '0;
    repeat (3) @(negedge clk);
    chk("R11 outputs in reset", outs(), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 outputs after reset", outs(), 0);
    repeat (5) @(negedge clk);
    chk("R1 no enable without stable", int'(align_en), 0);

    run_align(1);
    // R2: stable and divider changes after completion do not matter
    for (int i = 0; i < 20; i++) begin
      clocks_stable = 1'($urandom);
      div_sel = DIV_W'($urandom);
      @(negedge clk);
      if (i % 5 == 4) chk("R2 enable persists", outs(), 3'b101);
    end
    prev_done = 1'b1;

    // Directed: abort during settling with tile reset
    fire(0, 1'b1, prev_done);
    repeat (10) @(negedge clk);
    chk("R2 enable held in settle", int'(align_en), 1);
    fire(0, 1'b1, 1'b0);
    run_align(2);

    // Directed: abort during set-phase with source change
    fire(1, 1'b1, 1'b1);
    div_sel = 2'd3;
    clocks_stable = 1'b1;
    h = 0;
    while (!set_phase && h < 1000) begin
      h++;
      @(negedge clk);
    end
    repeat (5) @(negedge clk);
    chk("R4 pulse still high", int'(set_phase), 1);
    fire(1, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    chk("R10 waits for stable after restart", outs(), 0);
    run_align(0);

    // Constrained random restarts
    for (int t = 0; t < 24; t++) begin
      int ev;
      int d;
      int gap;
      ev  = int'($urandom % 3);
      d   = int'($urandom % 4);
      gap = int'($urandom % 4);
      fire(ev, gap == 0, 1'b1);
      if (gap > 0) begin
        repeat (gap) @(negedge clk);
        chk("R10 low until stable", outs(), 0);
      end
      run_align(d);
    end
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule